// File: doc/BRIEF.md
# Serial Configuration Loader for a Dual-Divider Synthesizer

The block takes a three-wire serial stream (data, serial clock, load strobe) from a slow host. It assembles a configuration word in a shift register and, on the strobe, copies that word into one of two holding registers. A routing bit decides which register receives it. That bit is the last bit shifted, so it sits in the least significant position.

One holding register carries the reference-path settings: a 14-bit reference ratio and four option flags. The flags select the prescaler modulus, the phase comparator polarity, the lock-detect/divided-output pin source and the charge pump current. The other holding register carries the main-path settings: a 7-bit swallow count and an 11-bit main count.

The serial pins are treated as asynchronous. They are synchronized into the system clock domain, and every action of the block is taken on detected edges there. Each holding register has a valid flag that rises on its first load.

Top module: `serial_cfg_loader`

## Requirements
- R1: After reset, every holding-register output is zero and both valid flags are low.
- R2: The shift register takes one bit from `ser_dat` on each rising edge of `ser_clk` while `ser_le` is low. Words are sent MSB first, so the final bit sent is bit 0, the routing bit.
- R3: On a rising edge of `ser_le` with bit 0 = 1, the reference register loads the word as follows. Bits 14:1 go to `ref_ratio`. Bit 15 goes to `pre_sel`, bit 16 to `pd_pol`, bit 17 to `ld_sel` and bit 18 to `cp_sel`.
- R4: On a rising edge of `ser_le` with bit 0 = 0, the main register loads the word as follows. Bits 7:1 go to `main_a` and bits 18:8 go to `main_n`.
- R5: A load into one holding register leaves the other register and its valid flag unchanged.
- R6: Rising edges of `ser_clk` while `ser_le` is high do not alter the shift register.
- R7: Holding-register outputs change only on a rising edge of `ser_le`. Shifting a new word with `ser_le` low, or holding `ser_le` high, does not change them.
- R8: `ref_valid` rises on the first reference load and `main_valid` on the first main load. Each stays high until reset.
- R9: When more than 19 bits are shifted before a strobe, only the last 19 bits sent form the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_dat | input | 1 | Serial data, MSB first (asynchronous) |
| ser_le | input | 1 | Load strobe, acts on its rising edge (asynchronous) |
| ref_ratio | output | 14 | Reference divider ratio |
| pre_sel | output | 1 | Prescaler modulus select |
| pd_pol | output | 1 | Phase comparator polarity |
| ld_sel | output | 1 | Lock-detect / divided-output select |
| cp_sel | output | 1 | Charge pump current select |
| main_a | output | 7 | Swallow count |
| main_n | output | 11 | Main count |
| ref_valid | output | 1 | Reference register has been loaded |
| main_valid | output | 1 | Main register has been loaded |

## Verification
The bench loads every swallow value and walks a single one through each ratio and count bit. A design with a field off by one position, or with the bit order reversed, would then show a wrong or moved bit.

It drives all sixteen flag combinations, to catch two flags that are swapped. It loads one register and then checks the other, to expose a strobe that writes both registers.

It sends a deliberately overlong word, which catches a shifter that keeps the first bits rather than the last. It toggles the serial clock with the strobe held high and then re-strobes with no new bits. A design that kept shifting would latch the garbage instead of repeating the earlier word.

// File: rtl/serial_cfg_pkg.sv
// Package: shared types for the serial configuration loader.
// Assumes: bit 0 of every word is the routing bit.
package serial_cfg_pkg;
    typedef enum logic {
        DEST_MAIN = 1'b0,
        DEST_REF  = 1'b1
    } cfg_dest_e;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/cfg_edge_sync.sv
// Module: cfg_edge_sync
// Brings WIDTH asynchronous inputs into the clk domain through STAGES flops each.
// It gives the synchronized level and a one-cycle rising-edge pulse per input.
// Assumes: inputs stay stable for at least STAGES+1 clk cycles between changes.
module cfg_edge_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise
);
    localparam int CHAIN = STAGES + 1;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [CHAIN-1:0] chain;

        // Shift the input through the synchronizer and the edge-history flop.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[CHAIN-2:0], async_in[b]};
        end

        assign level[b] = chain[STAGES-1];
        assign rise[b]  = chain[STAGES-1] & ~chain[STAGES];
    end
endmodule

// File: rtl/cfg_shifter.sv
// Module: cfg_shifter
// A WORD_W-bit shift register that takes a new bit at the LSB whenever shift_en is high.
// Older bits move toward the MSB and the oldest one drops off.
// Assumes: shift_en is a single-cycle pulse per serial clock edge.
module cfg_shifter #(
    parameter int WORD_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [WORD_W-1:0] word
);
    // Move the word up by one place and insert the new bit.
    always_ff @(posedge clk) begin
        if (!rst_n)        word <= '0;
        else if (shift_en) word <= {word[WORD_W-2:0], bit_in};
    end
endmodule

// File: rtl/cfg_dest_regs.sv
// Module: cfg_dest_regs
// Holds the two destination registers. On a load pulse, bit 0 of the word picks
// the target and the word is split into that target's fields.
// Assumes: the word is at least as wide as both layouts.
module cfg_dest_regs
    import serial_cfg_pkg::*;
#(
    parameter int REF_W  = 14,
    parameter int A_W    = 7,
    parameter int N_W    = 11,
    parameter int WORD_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    output logic [REF_W-1:0]  ref_ratio,
    output logic              pre_sel,
    output logic              pd_pol,
    output logic              ld_sel,
    output logic              cp_sel,
    output logic [A_W-1:0]    main_a,
    output logic [N_W-1:0]    main_n,
    output logic              ref_valid,
    output logic              main_valid
);
    localparam int FLAG_LSB = 1 + REF_W;
    localparam int N_LSB    = 1 + A_W;

    cfg_dest_e dest;
    assign dest = cfg_dest_e'(word[0]);

    // Capture the reference fields and flags on a reference load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_ratio <= '0;
            pre_sel   <= 1'b0;
            pd_pol    <= 1'b0;
            ld_sel    <= 1'b0;
            cp_sel    <= 1'b0;
            ref_valid <= 1'b0;
        end else if (load && dest == DEST_REF) begin
            ref_ratio <= word[REF_W:1];
            pre_sel   <= word[FLAG_LSB];
            pd_pol    <= word[FLAG_LSB+1];
            ld_sel    <= word[FLAG_LSB+2];
            cp_sel    <= word[FLAG_LSB+3];
            ref_valid <= 1'b1;
        end
    end

    // Capture the swallow and main counts on a main load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            main_a     <= '0;
            main_n     <= '0;
            main_valid <= 1'b0;
        end else if (load && dest == DEST_MAIN) begin
            main_a     <= word[A_W:1];
            main_n     <= word[N_LSB+N_W-1:N_LSB];
            main_valid <= 1'b1;
        end
    end
endmodule

// File: rtl/serial_cfg_loader.sv
// Module: serial_cfg_loader (top)
// Three-wire serial configuration loader. It synchronizes the serial pins and
// shifts bits while the strobe is low. On the strobe's rising edge it routes
// the word to the reference or main register.
// Assumes: the serial pins are slow relative to clk (each level held > SYNC_STAGES+1 cycles).
module serial_cfg_loader
    import serial_cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int REF_W       = 14,
    parameter int A_W         = 7,
    parameter int N_W         = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_clk,
    input  logic             ser_dat,
    input  logic             ser_le,
    output logic [REF_W-1:0] ref_ratio,
    output logic             pre_sel,
    output logic             pd_pol,
    output logic             ld_sel,
    output logic             cp_sel,
    output logic [A_W-1:0]   main_a,
    output logic [N_W-1:0]   main_n,
    output logic             ref_valid,
    output logic             main_valid
);
    localparam int REF_WORD = 1 + REF_W + 4;
    localparam int MAIN_WORD = 1 + A_W + N_W;
    localparam int WORD_W = max_u(REF_WORD, MAIN_WORD);

    logic [2:0] pin_level;
    logic [2:0] pin_rise;
    logic       shift_en;
    logic       le_rise;
    logic [WORD_W-1:0] sr_word;

    cfg_edge_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in({ser_le, ser_dat, ser_clk}),
        .level   (pin_level),
        .rise    (pin_rise)
    );

    assign shift_en = pin_rise[0] & ~pin_level[2];
    assign le_rise  = pin_rise[2];

    cfg_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(shift_en),
        .bit_in  (pin_level[1]),
        .word    (sr_word)
    );

    cfg_dest_regs #(.REF_W(REF_W), .A_W(A_W), .N_W(N_W), .WORD_W(WORD_W)) u_dest (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (le_rise),
        .word      (sr_word),
        .ref_ratio (ref_ratio),
        .pre_sel   (pre_sel),
        .pd_pol    (pd_pol),
        .ld_sel    (ld_sel),
        .cp_sel    (cp_sel),
        .main_a    (main_a),
        .main_n    (main_n),
        .ref_valid (ref_valid),
        .main_valid(main_valid)
    );
endmodule

// File: rtl/serial_cfg_loader_chk.sv
// Module: serial_cfg_loader_chk
// Checker bound into the top. It watches the load pulse, the routing bit and
// the shifter against the holding-register outputs.
module serial_cfg_loader_chk #(
    parameter int REF_W  = 14,
    parameter int A_W    = 7,
    parameter int N_W    = 11,
    parameter int WORD_W = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic              le_rise,
    input logic              shift_en,
    input logic              le_level,
    input logic [WORD_W-1:0] sr_word,
    input logic [REF_W-1:0]  ref_ratio,
    input logic              pre_sel,
    input logic              pd_pol,
    input logic              ld_sel,
    input logic              cp_sel,
    input logic [A_W-1:0]    main_a,
    input logic [N_W-1:0]    main_n,
    input logic              ref_valid,
    input logic              main_valid
);
    a_r3_ref_load_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (le_rise && sr_word[0]) |=> (ref_ratio == $past(sr_word[REF_W:1]) && ref_valid));

    a_r4_main_load_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (le_rise && !sr_word[0]) |=> (main_a == $past(sr_word[A_W:1]) && main_valid));

    a_r5_main_kept_on_ref_load: assert property (@(posedge clk) disable iff (!rst_n)
        (le_rise && sr_word[0]) |=> ($stable(main_a) && $stable(main_n) && $stable(main_valid)));

    a_r5_ref_kept_on_main_load: assert property (@(posedge clk) disable iff (!rst_n)
        (le_rise && !sr_word[0]) |=> ($stable(ref_ratio) && $stable(cp_sel) && $stable(ref_valid)));

    a_r6_no_shift_while_strobe_high: assert property (@(posedge clk) disable iff (!rst_n)
        (le_level && !le_rise) |=> $stable(sr_word));

    a_r7_outputs_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !le_rise |=> ($stable(ref_ratio) && $stable(pre_sel) && $stable(pd_pol) &&
                      $stable(ld_sel) && $stable(cp_sel) && $stable(main_a) && $stable(main_n)));

    a_r8_ref_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ref_valid |=> ref_valid);

    a_r8_main_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        main_valid |=> main_valid);
endmodule

bind serial_cfg_loader serial_cfg_loader_chk #(
    .REF_W(REF_W), .A_W(A_W), .N_W(N_W), .WORD_W(WORD_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .le_rise   (le_rise),
    .shift_en  (shift_en),
    .le_level  (pin_level[2]),
    .sr_word   (sr_word),
    .ref_ratio (ref_ratio),
    .pre_sel   (pre_sel),
    .pd_pol    (pd_pol),
    .ld_sel    (ld_sel),
    .cp_sel    (cp_sel),
    .main_a    (main_a),
    .main_n    (main_n),
    .ref_valid (ref_valid),
    .main_valid(main_valid)
);

// File: tb/sim_serial_cfg_loader.sv
// Bench for serial_cfg_loader: sweeps the fields and computes the expected values arithmetically.
module sim_serial_cfg_loader;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_dat = 1'b0;
    logic ser_le = 1'b0;
    logic [13:0] ref_ratio;
    logic pre_sel, pd_pol, ld_sel, cp_sel;
    logic [6:0] main_a;
    logic [10:0] main_n;
    logic ref_valid, main_valid;

    int checks = 0;
    int errors = 0;

    // Expected state, tracked by the bench.
    logic [17:0] exp_ref = '0;
    logic [17:0] exp_main = '0;
    logic exp_rv = 1'b0;
    logic exp_mv = 1'b0;

    always #4 clk = ~clk;

    serial_cfg_loader u0 (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_le(ser_le),
        .ref_ratio(ref_ratio), .pre_sel(pre_sel), .pd_pol(pd_pol), .ld_sel(ld_sel),
        .cp_sel(cp_sel), .main_a(main_a), .main_n(main_n),
        .ref_valid(ref_valid), .main_valid(main_valid)
    );

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Send nbits of w, MSB first; the last bit sent is w[0].
    task automatic send_bits(input logic [31:0] w, input int nbits);
        for (int i = nbits - 1; i >= 0; i--) begin
            ser_dat = w[i];
            wait_clk(4);
            ser_clk = 1'b1;
            wait_clk(4);
            ser_clk = 1'b0;
        end
    endtask

    task automatic strobe();
        ser_le = 1'b1;
        wait_clk(8);
        ser_le = 1'b0;
        wait_clk(8);
    endtask

    task automatic compare_all(input string req);
        check(req, {ref_ratio, pre_sel, pd_pol, ld_sel, cp_sel},
              {exp_ref[13:0], exp_ref[14], exp_ref[15], exp_ref[16], exp_ref[17]});
        check(req, {main_n, main_a}, exp_main);
        check(req, {ref_valid, main_valid}, {exp_rv, exp_mv});
    endtask

    // Reference word: bit0=1, bits14:1 ratio, 15 prescaler, 16 polarity, 17 lock select, 18 pump.
    task automatic load_ref(input logic [13:0] r, input logic [3:0] f, input string req);
        logic [18:0] w;
        w = {f[3], f[2], f[1], f[0], r, 1'b1};
        send_bits({13'd0, w}, 19);
        strobe();
        exp_ref = {f, r};
        exp_rv = 1'b1;
        compare_all(req);
    endtask

    // Main word: bit0=0, bits7:1 swallow, bits18:8 main count.
    task automatic load_main(input logic [6:0] a, input logic [10:0] n, input string req);
        send_bits({13'd0, n, a, 1'b0}, 19);
        strobe();
        exp_main = {n, a};
        exp_mv = 1'b1;
        compare_all(req);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog timeout actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stim
        wait_clk(5);
        check("R1 reset outputs", {ref_ratio, pre_sel, pd_pol, ld_sel, cp_sel, main_a, main_n}, 0);
        check("R1 reset valid", {ref_valid, main_valid}, 0);
        rst_n = 1'b1;
        wait_clk(5);

        // R4 / R8: first main load raises only main_valid.
        load_main(7'd5, 11'd3, "R4 R8 first main");
        // R3 / R5: walking one through the reference ratio.
        for (int i = 0; i < 14; i++) load_ref(14'd1 << i, 4'h0, "R3 R5 ratio walk");
        // R3: all flag combinations.
        for (int f = 0; f < 16; f++) load_ref(14'h2aaa ^ 14'(f), 4'(f), "R3 flags");
        // R4 / R2: every swallow value.
        for (int a = 0; a < 128; a++) load_main(7'(a), 11'(a * 13 + 7), "R4 R2 swallow sweep");
        // R4: walking one through the main count.
        for (int i = 0; i < 11; i++) load_main(7'h55, 11'd1 << i, "R4 count walk");

        // R7: shift a new word with the strobe low; outputs must not move.
        send_bits({13'd0, 11'h7ff, 7'h7f, 1'b0}, 19);
        wait_clk(10);
        compare_all("R7 shift without strobe");

        // R6: load ref, keep strobe high, toggle garbage, then re-strobe without shifting.
        send_bits({13'd0, 4'b1010, 14'h1234, 1'b1}, 19);
        ser_le = 1'b1;
        wait_clk(8);
        exp_ref = {4'b1010, 14'h1234};
        compare_all("R7 strobe held");
        send_bits(32'h0000_0000, 19);
        wait_clk(4);
        compare_all("R7 clocks while strobe high");
        ser_le = 1'b0;
        wait_clk(8);
        strobe();
        compare_all("R6 re-strobe repeats earlier word");

        // R9: overlong word, the leading garbage bits are dropped.
        send_bits({6'b111111, 11'h4c1, 7'h2e, 1'b0}, 25);
        strobe();
        exp_main = {11'h4c1, 7'h2e};
        compare_all("R9 overlong word");

        // R1: reset clears everything again.
        rst_n = 1'b0;
        wait_clk(3);
        check("R1 reset again", {ref_ratio, pre_sel, pd_pol, ld_sel, cp_sel, main_a, main_n, ref_valid, main_valid}, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule